// File: doc/BRIEF.md
# Time-Qualified Pattern Trigger Unit

This block decides when a two-channel digitizer should start its capture. On every clock it sees one comparator bit per channel, which is already digitized and reads 1 when the signal is above its threshold. After an arm strobe it watches for the trigger condition the configuration selects and then emits a single-cycle trigger pulse. The unit then stays idle until it is armed again.

Five conditions can be selected:
- an immediate trigger straight after arming;
- an edge on one chosen channel;
- entry into, or exit from, a per-channel high/low/don't-care pattern;
- exit from a pattern whose duration meets a greater-than, less-than or in-range test;
- the n-th occurrence of an edge or of a pattern exit, where only the first occurrence must pass the duration test.

A programmable timeout gives a fallback. If nothing qualifies in time, the unit fires anyway and raises a flag that marks the trigger as automatic.

All durations are counted in clock cycles. The unit has no data stream and therefore no back-pressure. Every pin is a plain level or strobe sampled on the rising clock edge, and the configuration pins must be held steady while the unit is armed.

Top module: `trig_unit`

## Requirements
- R1: After reset `trig_o` and `auto_o` are 0 and the unit is disarmed. Without an `arm_i` strobe, `trig_o` never rises, whatever the comparator inputs do.
- R2: Mode code 0 (immediate). A clock edge that samples `arm_i`=1 makes `trig_o`=1 in the following cycle, with `auto_o`=0.
- R3: Mode code 1 (edge). `edge_sel_i` picks the channel (bit index into `ch_i`). With `edge_fall_i`=0 the trigger fires on a 0→1 change between consecutive samples of that channel, and with `edge_fall_i`=1 on a 1→0 change. `trig_o` rises in the cycle after the edge that samples the new value.
- R4: A sample matches the pattern when every channel with `pat_care_i` bit = 1 equals its `pat_val_i` bit; channels with a care bit of 0 are don't-care. Mode code 2 with `pat_exit_i`=0 fires once the match has held for `min_len_i` consecutive armed samples. A `min_len_i` of 0 acts as 1.
- R5: Mode code 2 with `pat_exit_i`=1 fires on the first non-matching sample after a run of at least `min_len_i` matching samples. Shorter runs are ignored.
- R6: Mode code 3 fires on pattern exit when the run length d (counted as in R5) passes the test chosen by `qual_sel_i`: 0 means d > `lim_lo_i`, 1 means d < `lim_hi_i`, 2 means `lim_lo_i` ≤ d ≤ `lim_hi_i`, and 3 never passes.
- R7: A run that fails the duration test leaves nothing behind. A new run that starts after one non-matching sample is judged on its own length.
- R8: Mode code 4 fires on the n-th event, where n = `evt_n_i` and 0 acts as 1. With `evt_pat_i`=0 the events are edges as in R3. With `evt_pat_i`=1 the first event must be a duration-qualified exit as in R6, and each later event is any exit of a run of at least `min_len_i` samples.
- R9: When `timeout_i` is non-zero and no condition fires on the first `timeout_i` armed clock edges, `trig_o` and `auto_o` are both 1 in the cycle after the last of those edges. A `timeout_i` of 0 disables this fallback. A real condition on the same edge wins and leaves `auto_o` at 0.
- R10: The run-length counter saturates at 2^DW−1 and does not wrap.
- R11: `trig_o` is a one-cycle pulse. After it the unit ignores all conditions until the next `arm_i`.
- R12: An `arm_i` strobe while the unit is armed restarts the run-length counter, the event count and the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm strobe; it also restarts all counters |
| ch_i | input | NCH | Above-threshold bit per channel |
| mode_i | input | 3 | Trigger condition code (0–4) |
| edge_sel_i | input | SW | Channel used for edges |
| edge_fall_i | input | 1 | 0 = rising edge, 1 = falling edge |
| pat_care_i | input | NCH | 1 = channel takes part in the pattern |
| pat_val_i | input | NCH | Required level of each cared channel |
| pat_exit_i | input | 1 | Pattern mode: 0 = entry, 1 = exit |
| min_len_i | input | DW | Minimum run length for recognition |
| qual_sel_i | input | 2 | Duration test code |
| lim_lo_i | input | DW | Lower duration limit |
| lim_hi_i | input | DW | Upper duration limit |
| evt_pat_i | input | 1 | Event-delay source: 0 = edge, 1 = pattern |
| evt_n_i | input | CW | Event count n |
| timeout_i | input | TW | Auto-trigger timeout in cycles; 0 disables it |
| trig_o | output | 1 | One-cycle trigger pulse |
| auto_o | output | 1 | Marks a trigger produced by the timeout |

## Verification
The bound checker tests properties that must hold on every cycle:
- `trig_o` is a single-cycle pulse and only ever follows an armed state or an arm strobe;
- the unit disarms only by triggering;
- `auto_o` never appears without `trig_o`;
- an immediate-mode arm is always answered on the next cycle;
- a saturated run length stays saturated.

Whether the right cycle fires for a given pattern history depends on data. This covers the duration test, the first-event-only qualification, the one-cycle recovery and the exact timeout cycle, and only the bench's scenarios can show it. The bench compares every cycle against its own cycle model of the requirements.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [2:0] {
    TM_IMM   = 3'd0,
    TM_EDGE  = 3'd1,
    TM_PAT   = 3'd2,
    TM_TQUAL = 3'd3,
    TM_DELAY = 3'd4
  } trig_mode_e;

  typedef enum logic [1:0] {
    QC_GT  = 2'd0,
    QC_LT  = 2'd1,
    QC_IN  = 2'd2,
    QC_OFF = 2'd3
  } qual_sel_e;
endpackage

// File: rtl/trig_runlen.sv
module trig_runlen #(
  parameter int NCH = 2,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NCH-1:0] ch,
  input  logic [NCH-1:0] care,
  input  logic [NCH-1:0] val,
  output logic           match,
  output logic           match_q,
  output logic [DW-1:0]  len_q
);
  localparam logic [DW-1:0] LMAX = {DW{1'b1}};

  logic [NCH-1:0] lane_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign lane_ok[g] = !care[g] || (ch[g] == val[g]);
  end

  assign match = &lane_ok;

  // saturating run counter of consecutive matching samples (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (clr || !match) len_q <= '0;
      else if (len_q != LMAX) len_q <= len_q + 1'b1;
    end
  end
endmodule

// File: rtl/trig_evcount.sv
module trig_evcount #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          ev_first,
  input  logic          ev_more,
  input  logic [CW-1:0] n,
  output logic          hit
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   n_eff;
  logic          ev;

  assign n_eff = (n == '0) ? (CW+1)'(1) : {1'b0, n};
  assign ev    = (cnt_q == '0) ? ev_first : ev_more;
  assign hit   = en && ev && (({1'b0, cnt_q} + 1'b1) >= n_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en && ev && !hit) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/trig_timeout.sv
module trig_timeout #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] tq;

  assign expire = run && (limit != '0) && (tq == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tq <= '0;
    else if (clr) tq <= '0;
    else if (run) tq <= tq + 1'b1;
  end
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int CW  = 8,
  parameter int TW  = 16,
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm_i,
  input  logic [NCH-1:0] ch_i,
  input  logic [2:0]     mode_i,
  input  logic [SW-1:0]  edge_sel_i,
  input  logic           edge_fall_i,
  input  logic [NCH-1:0] pat_care_i,
  input  logic [NCH-1:0] pat_val_i,
  input  logic           pat_exit_i,
  input  logic [DW-1:0]  min_len_i,
  input  logic [1:0]     qual_sel_i,
  input  logic [DW-1:0]  lim_lo_i,
  input  logic [DW-1:0]  lim_hi_i,
  input  logic           evt_pat_i,
  input  logic [CW-1:0]  evt_n_i,
  input  logic [TW-1:0]  timeout_i,
  output logic           trig_o,
  output logic           auto_o
);
  localparam logic [DW-1:0] LMAX = {DW{1'b1}};

  trig_mode_e     mode;
  qual_sel_e      qsel;
  logic           armed_q;
  logic [NCH-1:0] ch_q;
  logic           pat_hit, pat_hit_q;
  logic [DW-1:0]  len_q, cur_len, min_eff;
  logic           edge_ev, enter_ev, exit_ev, qual_ok;
  logic           live, cnt_hit, expire, cond_now;
  logic           fire_evt, fire_auto, imm_fire;

  assign mode = trig_mode_e'(mode_i);
  assign qsel = qual_sel_e'(qual_sel_i);
  assign live = armed_q && !arm_i;

  trig_runlen #(.NCH(NCH), .DW(DW)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(arm_i), .ch(ch_i),
    .care(pat_care_i), .val(pat_val_i),
    .match(pat_hit), .match_q(pat_hit_q), .len_q(len_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_q <= '0;
    else ch_q <= ch_i;
  end

  assign edge_ev = edge_fall_i ? (ch_q[edge_sel_i] && !ch_i[edge_sel_i])
                               : (!ch_q[edge_sel_i] && ch_i[edge_sel_i]);

  assign min_eff  = (min_len_i == '0) ? DW'(1) : min_len_i;
  assign cur_len  = (len_q == LMAX) ? LMAX : len_q + 1'b1;
  assign enter_ev = pat_hit && (cur_len == min_eff);
  assign exit_ev  = !pat_hit && pat_hit_q && (len_q >= min_eff);

  always_comb begin
    unique case (qsel)
      QC_GT:   qual_ok = len_q > lim_lo_i;
      QC_LT:   qual_ok = len_q < lim_hi_i;
      QC_IN:   qual_ok = (len_q >= lim_lo_i) && (len_q <= lim_hi_i);
      default: qual_ok = 1'b0;
    endcase
  end

  trig_evcount #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(arm_i),
    .en(live && (mode == TM_DELAY)),
    .ev_first(evt_pat_i ? (exit_ev && qual_ok) : edge_ev),
    .ev_more(evt_pat_i ? exit_ev : edge_ev),
    .n(evt_n_i), .hit(cnt_hit)
  );

  always_comb begin
    unique case (mode)
      TM_EDGE:  cond_now = edge_ev;
      TM_PAT:   cond_now = pat_exit_i ? exit_ev : enter_ev;
      TM_TQUAL: cond_now = exit_ev && qual_ok;
      TM_DELAY: cond_now = cnt_hit;
      default:  cond_now = 1'b0;
    endcase
  end

  trig_timeout #(.TW(TW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(arm_i),
    .run(live && !cond_now), .limit(timeout_i), .expire(expire)
  );

  assign imm_fire  = arm_i && (mode == TM_IMM);
  assign fire_evt  = live && cond_now;
  assign fire_auto = expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_o  <= 1'b0;
      auto_o  <= 1'b0;
    end else begin
      trig_o <= imm_fire || fire_evt || fire_auto;
      auto_o <= fire_auto;
      if (arm_i) armed_q <= !imm_fire;
      else if (fire_evt || fire_auto) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm_i,
  input logic [2:0]    mode_i,
  input logic          trig_o,
  input logic          auto_o,
  input logic          armed_q,
  input logic          pat_hit,
  input logic [DW-1:0] len_q
);
  localparam logic [DW-1:0] LMAX = {DW{1'b1}};

  // R11
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && !arm_i) |=> !trig_o);

  // R1
  needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(armed_q || arm_i));

  // R11
  disarm_only_by_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_q) |-> trig_o);

  // R9
  auto_with_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_o |-> trig_o);

  // R2
  immediate_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && mode_i == 3'd0) |=> (trig_o && !auto_o));

  // R10
  len_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == LMAX && pat_hit && !arm_i) |=> (len_q == LMAX));
endmodule

bind trig_unit trig_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .mode_i(mode_i),
  .trig_o(trig_o), .auto_o(auto_o), .armed_q(armed_q),
  .pat_hit(pat_hit), .len_q(len_q)
);

// File: tb/sim_trig_unit.sv
module sim_trig_unit;
  localparam int NCH  = 2;
  localparam int DW   = 8;
  localparam int CW   = 8;
  localparam int TW   = 16;
  localparam int MAXL = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic [1:0] ch = '0;
  logic [2:0] mode = '0;
  logic esel = 1'b0, efall = 1'b0;
  logic [1:0] care = '0, pval = '0;
  logic pexit = 1'b0, src = 1'b0;
  logic [DW-1:0] minl = '0, lo = '0, hi = '0;
  logic [1:0] qsel = '0;
  logic [CW-1:0] evn = '0;
  logic [TW-1:0] tmo = '0;
  logic trig_o, auto_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench cycle model state
  bit m_armed, m_mq, e_trig, e_auto;
  bit [1:0] m_chq;
  int m_len, m_cnt, m_tmr;

  always #5 clk = ~clk;

  trig_unit #(.NCH(NCH), .DW(DW), .CW(CW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .ch_i(ch), .mode_i(mode),
    .edge_sel_i(esel), .edge_fall_i(efall), .pat_care_i(care),
    .pat_val_i(pval), .pat_exit_i(pexit), .min_len_i(minl),
    .qual_sel_i(qsel), .lim_lo_i(lo), .lim_hi_i(hi), .evt_pat_i(src),
    .evt_n_i(evn), .timeout_i(tmo), .trig_o(trig_o), .auto_o(auto_o)
  );

  function automatic bit pat_ok(input logic [1:0] c);
    pat_ok = 1'b1;
    for (int i = 0; i < 2; i++)
      if (care[i] && c[i] != pval[i]) pat_ok = 1'b0;
  endfunction

  function automatic bit qual(input int d);
    case (qsel)
      2'd0: qual = d > int'(lo);
      2'd1: qual = d < int'(hi);
      2'd2: qual = d >= int'(lo) && d <= int'(hi);
      default: qual = 1'b0;
    endcase
  endfunction

  task automatic model_step();
    int mn, cur, nn;
    bit mt, ex, en, ed, ev, e1;
    mn  = (minl == 0) ? 1 : int'(minl);
    nn  = (evn == 0) ? 1 : int'(evn);
    mt  = pat_ok(ch);
    cur = (m_len == MAXL) ? MAXL : m_len + 1;
    ex  = !mt && m_mq && m_len >= mn;
    en  = mt && cur == mn;
    ed  = efall ? (m_chq[esel] && !ch[esel]) : (!m_chq[esel] && ch[esel]);
    e_trig = 0; e_auto = 0;
    if (arm) begin
      if (mode == 3'd0) begin e_trig = 1; m_armed = 0; end
      else m_armed = 1;
      m_cnt = 0; m_tmr = 0;
    end else if (m_armed) begin
      ev = 0;
      case (mode)
        3'd1: ev = ed;
        3'd2: ev = pexit ? ex : en;
        3'd3: ev = ex && qual(m_len);
        3'd4: begin
          e1 = src ? ((m_cnt == 0) ? (ex && qual(m_len)) : ex) : ed;
          if (e1) begin
            if (m_cnt + 1 >= nn) ev = 1;
            else m_cnt++;
          end
        end
        default: ev = 0;
      endcase
      if (ev) begin e_trig = 1; m_armed = 0; end
      else if (tmo != 0 && m_tmr == int'(tmo) - 1) begin
        e_trig = 1; e_auto = 1; m_armed = 0;
      end else m_tmr++;
    end
    m_len = arm ? 0 : (mt ? cur : 0);
    m_chq = ch; m_mq = mt;
  endtask

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(trig_o, e_trig, tag, "trig_o");
    if (auto_o !== e_auto) check(auto_o, e_auto, tag, "auto_o");
  endtask

  task automatic hold(input logic [1:0] v, input int n, input string tag);
    ch = v;
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic do_arm(input string tag);
    arm = 1; tick(tag); arm = 0;
  endtask

  task automatic defaults();
    mode = 3'd1; esel = 0; efall = 0; care = 2'b11; pval = 2'b11;
    pexit = 0; minl = 1; qsel = 2'd0; lo = 0; hi = 0; src = 0;
    evn = 1; tmo = 0;
  endtask

  initial begin
    defaults();
    m_armed = 0; m_mq = 0; m_chq = 0; m_len = 0; m_cnt = 0; m_tmr = 0;
    repeat (3) @(negedge clk);
    check(trig_o, 0, "R1", "reset trig");
    check(auto_o, 0, "R1", "reset auto");
    rst_n = 1;

    // R1: activity without arm gives nothing
    hold(2'b00, 2, "R1"); hold(2'b11, 3, "R1"); hold(2'b01, 2, "R1");

    // R2: immediate
    mode = 3'd0; do_arm("R2");
    check(trig_o, 1, "R2", "imm trig");
    tick("R11"); check(trig_o, 0, "R11", "pulse one cycle");

    // R3: rising edge on channel 1, then falling on channel 0
    defaults(); esel = 1; ch = 2'b00; do_arm("R3");
    hold(2'b01, 2, "R3");
    ch = 2'b10; tick("R3"); check(trig_o, 1, "R3", "rise ch1");
    hold(2'b00, 2, "R11");
    efall = 1; esel = 0; ch = 2'b01; do_arm("R3");
    ch = 2'b00; tick("R3"); check(trig_o, 1, "R3", "fall ch0");

    // R4: entry after 3 samples, channel 0 don't-care
    defaults(); mode = 3'd2; care = 2'b10; pval = 2'b10; minl = 3;
    ch = 2'b00; do_arm("R4");
    hold(2'b10, 2, "R4"); hold(2'b00, 1, "R4"); hold(2'b11, 4, "R4");

    // R5: exit, short run ignored
    defaults(); mode = 3'd2; pexit = 1; minl = 3; ch = 2'b00; do_arm("R5");
    hold(2'b11, 2, "R5"); hold(2'b00, 2, "R5"); hold(2'b11, 3, "R5"); hold(2'b00, 2, "R5");

    // R6: in-range test
    defaults(); mode = 3'd3; qsel = 2'd2; lo = 3; hi = 5; ch = 2'b00; do_arm("R6");
    hold(2'b11, 2, "R6"); hold(2'b00, 1, "R6"); hold(2'b11, 7, "R6");
    hold(2'b00, 1, "R6"); hold(2'b11, 4, "R6"); hold(2'b00, 2, "R6");

    // R7: failed run then one-cycle gap
    defaults(); mode = 3'd3; qsel = 2'd1; hi = 3; ch = 2'b00; do_arm("R7");
    hold(2'b11, 5, "R7"); hold(2'b00, 1, "R7"); hold(2'b11, 2, "R7");
    ch = 2'b00; tick("R7"); check(trig_o, 1, "R7", "qualified after recovery");

    // R8: n=3, only first qualified
    defaults(); mode = 3'd4; src = 1; evn = 3; qsel = 2'd0; lo = 3; ch = 2'b00; do_arm("R8");
    hold(2'b11, 2, "R8"); hold(2'b00, 1, "R8"); hold(2'b11, 5, "R8"); hold(2'b00, 1, "R8");
    hold(2'b11, 1, "R8"); hold(2'b00, 1, "R8"); hold(2'b11, 1, "R8"); hold(2'b00, 2, "R8");
    defaults(); mode = 3'd4; evn = 0; ch = 2'b00; do_arm("R8");
    hold(2'b01, 2, "R8");

    // R9: auto trigger after 5 armed edges
    defaults(); tmo = 5; ch = 2'b00; do_arm("R9");
    hold(2'b00, 4, "R9");
    tick("R9"); check(trig_o, 1, "R9", "auto trig"); check(auto_o, 1, "R9", "auto flag");

    // R12: re-arm restarts the timeout
    do_arm("R12"); hold(2'b00, 3, "R12"); do_arm("R12"); hold(2'b00, 6, "R12");

    // R10: saturation of a long run
    defaults(); mode = 3'd3; qsel = 2'd0; lo = 254; ch = 2'b00; do_arm("R10");
    hold(2'b11, 300, "R10");
    ch = 2'b00; tick("R10"); check(trig_o, 1, "R10", "saturated run passes >254");

    // random episodes
    void'($urandom(32'd2024));
    for (int e = 0; e < 200; e++) begin
      mode = 3'($urandom_range(0, 5)); esel = 1'($urandom); efall = 1'($urandom);
      care = 2'($urandom); pval = 2'($urandom); pexit = 1'($urandom);
      minl = DW'($urandom_range(0, 4)); qsel = 2'($urandom);
      lo = DW'($urandom_range(0, 8)); hi = DW'($urandom_range(0, 10));
      src = 1'($urandom); evn = CW'($urandom_range(0, 4));
      tmo = TW'($urandom_range(0, 50));
      do_arm("R12");
      for (int c = 0; c < 40; c++) begin
        if ($urandom_range(0, 3) == 0) ch = 2'($urandom);
        arm = ($urandom_range(0, 59) == 0);
        tick("R8");
        arm = 0;
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule